// File: doc/BRIEF.md
# PHY Management Serial Master

This block drives a two-wire PHY management bus on behalf of software. Software sees three 32-bit words: a command word, a data word and a status word. Writing the command word with the busy bit and one operation bit set launches exactly one management frame. The frame is a long run of ones, a start code, an opcode, a PHY address, a register number, a turnaround and sixteen data bits. The busy bit stays set until the last bit has been clocked out. Software polls it before it issues the next command.

A write sends the low sixteen bits of the data word. A read releases the data line at the turnaround and shifts the PHY's sixteen bits into the upper half of the data word. A read also records in the status word whether the PHY pulled the second turnaround bit low. The management clock comes from the system clock through a parameterised divider. Its default keeps the clock at or below 2.5 MHz from a 100 MHz system clock. The clock stays low whenever no frame is running.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset, all three register words (command at word 0, data at word 1, status at word 2) read zero, and the management clock and the data-line enable are both low.
- R2: A write to the command word is accepted only if all three conditions hold: bit 20 (busy) is set, exactly one of bit 17 (read) and bit 16 (write) is set, and the block is idle. From the next cycle, an accepted command reads back with bit 20 set. Any other command write starts no frame and leaves busy clear.
- R3: A command write made while busy is set starts no frame and changes none of the command word's fields.
- R4: While a frame runs, the management clock has a period of 2*MDC_HALF_DIV system clocks. It is held low when idle.
- R5: Each frame starts with PRE_LEN ones, then 01, then the opcode (10 for a read, 01 for a write), then command bits 12:8 as the PHY address and command bits 4:0 as the register number, all sent MSB first.
- R6: A write continues with turnaround 10 and then data word bits 15:0, MSB first. The data line is driven for every bit of the frame.
- R7: A read releases the data line from the first turnaround bit to the end of the frame. It samples the sixteen data bits on rising clock edges into data word bits 31:16 and leaves bits 15:0 unchanged.
- R8: At the end of each read, status bit 0 is set if the second turnaround bit sampled high and cleared if it sampled low. A write leaves status bit 0 unchanged.
- R9: Busy reads clear once the frame's last clock period has completed. The data line is released by then.
- R10: The data output changes only while the management clock is low. It never changes while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 command, 1 data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Writes use two address and data patterns, one all zeros with a single one and one near all ones, so that shifted or swapped field bits show on the wire. Reads run against a PHY model that returns two distinct words. One read gets a correct turnaround and one does not, which separates the valid and invalid status outcomes and shows that a following write leaves the flag alone. Three kinds of bad command are tried: a second command during a running frame, a command with both operation bits set, and a command without the busy bit. Counting the frames on the wire tells these ignored commands apart from accepted ones.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int CMD_BUSY_BIT = 20;
   localparam int CMD_RD_BIT   = 17;
   localparam int CMD_WR_BIT   = 16;
   localparam int CMD_PHY_LSB  = 8;
   localparam int CMD_REG_LSB  = 0;
   localparam int ADDR_BITS    = 5;
   localparam int WORD_BITS    = 16;
   localparam int RDATA_LSB    = 16;
   localparam int STAT_INV_BIT = 0;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic                 is_rd;
      logic                 is_wr;
      logic [ADDR_BITS-1:0] phy;
      logic [ADDR_BITS-1:0] regn;
   } mgmt_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int HALF_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic mdc_o,
   output logic rise_o,
   output logic fall_o
);

   logic mdc_q;
   logic edge_now;

   generate
      if (HALF_DIV < 1) begin : g_bad
         $error("HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_direct
         assign edge_now = run_i;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign edge_now = run_i && (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
      end else if (!run_i) begin
         mdc_q <= 1'b0;
      end else if (edge_now) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc_o  = mdc_q;
   assign rise_o = edge_now && !mdc_q;
   assign fall_o = edge_now && mdc_q;

   // R4
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !mdc_o);

   // R4
   mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> mdc_o);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 rd_i,
   input  logic [ADDR_BITS-1:0] phy_i,
   input  logic [ADDR_BITS-1:0] reg_i,
   input  logic [WORD_BITS-1:0] wdata_i,
   input  logic                 rise_i,
   input  logic                 fall_i,
   input  logic                 mdio_i,
   output logic                 active_o,
   output logic                 mdio_o,
   output logic                 mdio_oe_o,
   output logic                 done_o,
   output logic [WORD_BITS-1:0] rdata_o,
   output logic                 rinvalid_o
);

   localparam int FLEN   = PRE_LEN + 4 + 2 * ADDR_BITS + 2 + WORD_BITS;
   localparam int CW     = $clog2(FLEN);
   localparam int TA1    = PRE_LEN + 4 + 2 * ADDR_BITS;
   localparam int TA2    = TA1 + 1;
   localparam int DATA0  = TA1 + 2;
   localparam logic [CW-1:0] LAST_IDX = CW'(FLEN - 1);
   localparam logic [CW-1:0] TA1_IDX  = CW'(TA1);
   localparam logic [CW-1:0] TA2_IDX  = CW'(TA2);
   localparam logic [CW-1:0] DAT_IDX  = CW'(DATA0);

   generate
      if (PRE_LEN < 1) begin : g_bad
         $error("PRE_LEN must be at least 1");
      end
   endgenerate

   logic                 active_q;
   logic                 rd_q;
   logic [CW-1:0]        bit_q;
   logic [FLEN-1:0]      sh_q;
   logic                 oe_q;
   logic                 done_q;
   logic [WORD_BITS-1:0] rx_q;
   logic                 inv_q;
   logic [FLEN-1:0]      load_word;

   always_comb begin
      load_word = {{PRE_LEN{1'b1}}, 2'b01,
                   (rd_i ? 2'b10 : 2'b01),
                   phy_i, reg_i,
                   (rd_i ? 2'b11 : 2'b10),
                   (rd_i ? {WORD_BITS{1'b1}} : wdata_i)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         bit_q    <= '0;
         sh_q     <= '0;
         oe_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !active_q) begin
            active_q <= 1'b1;
            rd_q     <= rd_i;
            bit_q    <= '0;
            sh_q     <= load_word;
            oe_q     <= 1'b1;
         end else if (active_q && fall_i) begin
            if (bit_q == LAST_IDX) begin
               active_q <= 1'b0;
               oe_q     <= 1'b0;
               done_q   <= 1'b1;
            end else begin
               bit_q <= bit_q + 1'b1;
               sh_q  <= {sh_q[FLEN-2:0], 1'b1};
               if (rd_q && (bit_q + 1'b1) == TA1_IDX) begin
                  oe_q <= 1'b0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q  <= '0;
         inv_q <= 1'b0;
      end else if (active_q && rd_q && rise_i) begin
         if (bit_q == TA2_IDX) begin
            inv_q <= mdio_i;
         end else if (bit_q >= DAT_IDX) begin
            rx_q <= {rx_q[WORD_BITS-2:0], mdio_i};
         end
      end
   end

   assign active_o   = active_q;
   assign mdio_o     = sh_q[FLEN-1];
   assign mdio_oe_o  = oe_q;
   assign done_o     = done_q;
   assign rdata_o    = rx_q;
   assign rinvalid_o = inv_q;

   // R7
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && rd_q && bit_q >= TA1_IDX) |-> !mdio_oe_o);

   // R9
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !mdio_oe_o);

   // R6
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !rd_q) |-> mdio_oe_o);

endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int MDC_HALF_DIV = 20,
   parameter int PRE_LEN      = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   generate
      if (CMD_BUSY_BIT > 31 || CMD_PHY_LSB + ADDR_BITS > CMD_WR_BIT) begin : g_bad_map
         $error("command field layout does not fit");
      end
   endgenerate

   mgmt_cmd_t            cmd_q;
   logic                 busy_q;
   logic [31:0]          data_q;
   logic                 inv_q;
   logic                 cmd_we;
   logic                 accept;
   logic                 run;
   logic                 rise;
   logic                 fall;
   logic                 done;
   logic [WORD_BITS-1:0] rx_word;
   logic                 rx_inv;
   logic                 op_ok;

   assign cmd_we = reg_we && (reg_sel_e'(reg_addr) == SEL_CMD);
   assign op_ok  = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
   assign accept = cmd_we && !busy_q && reg_wdata[CMD_BUSY_BIT] && op_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         busy_q <= 1'b0;
      end else if (accept) begin
         cmd_q.is_rd <= reg_wdata[CMD_RD_BIT];
         cmd_q.is_wr <= reg_wdata[CMD_WR_BIT];
         cmd_q.phy   <= reg_wdata[CMD_PHY_LSB +: ADDR_BITS];
         cmd_q.regn  <= reg_wdata[CMD_REG_LSB +: ADDR_BITS];
         busy_q      <= 1'b1;
      end else if (done) begin
         busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         inv_q  <= 1'b0;
      end else begin
         if (reg_we && reg_sel_e'(reg_addr) == SEL_DATA) begin
            data_q <= reg_wdata;
         end else if (done && cmd_q.is_rd) begin
            data_q[RDATA_LSB +: WORD_BITS] <= rx_word;
         end
         if (done && cmd_q.is_rd) begin
            inv_q <= rx_inv;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel_e'(reg_addr))
         SEL_CMD: begin
            reg_rdata[CMD_BUSY_BIT]                 = busy_q;
            reg_rdata[CMD_RD_BIT]                   = cmd_q.is_rd;
            reg_rdata[CMD_WR_BIT]                   = cmd_q.is_wr;
            reg_rdata[CMD_PHY_LSB +: ADDR_BITS]     = cmd_q.phy;
            reg_rdata[CMD_REG_LSB +: ADDR_BITS]     = cmd_q.regn;
         end
         SEL_DATA: reg_rdata = data_q;
         SEL_STAT: reg_rdata[STAT_INV_BIT] = inv_q;
         default:  reg_rdata = '0;
      endcase
   end

   mdio_clk_div #(
      .HALF_DIV (MDC_HALF_DIV)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .mdc_o  (mdc),
      .rise_o (rise),
      .fall_o (fall)
   );

   mdio_frame_seq #(
      .PRE_LEN (PRE_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .rd_i       (reg_wdata[CMD_RD_BIT]),
      .phy_i      (reg_wdata[CMD_PHY_LSB +: ADDR_BITS]),
      .reg_i      (reg_wdata[CMD_REG_LSB +: ADDR_BITS]),
      .wdata_i    (data_q[WORD_BITS-1:0]),
      .rise_i     (rise),
      .fall_i     (fall),
      .mdio_i     (mdio_i),
      .active_o   (run),
      .mdio_o     (mdio_o),
      .mdio_oe_o  (mdio_oe),
      .done_o     (done),
      .rdata_o    (rx_word),
      .rinvalid_o (rx_inv)
   );

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_q && run));

   // R3
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cmd_we) |=> $stable(cmd_q));

   // R10
   mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o));

   // R8
   stat_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cmd_q.is_rd) |=> $stable(inv_q));

   // R9
   busy_tracks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> busy_q);

endmodule

// File: tb/phy_mgmt_master_tb.sv
module phy_mgmt_master_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i;

   always #5 clk = ~clk;

   phy_mgmt_master #(.MDC_HALF_DIV(2), .PRE_LEN(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      logic [63:0] bits;
      bit          rd;
   } exp_t;
   exp_t expq[$];

   int          bit_idx = 64;
   logic        ta_drive = 1'b0;
   logic [15:0] resp = 16'h0;
   int          frames = 0;
   logic [63:0] cap_o, cap_oe;
   longint      t_prev = 0;

   assign mdio_i = (bit_idx == 47) ? ta_drive :
                   ((bit_idx >= 48 && bit_idx <= 63) ? resp[4'(63 - bit_idx)] : 1'b1);

   always @(negedge mdc) bit_idx++;

   // monitor: rebuild each frame from the wire and compare with the scoreboard
   always @(posedge mdc) begin
      if (bit_idx < 64) begin
         cap_o[63 - bit_idx]  = mdio_o;
         cap_oe[63 - bit_idx] = mdio_oe;
      end
      if (bit_idx == 1) chk("R4 mdc period", 64'($time - t_prev), 64'd40);
      t_prev = $time;
      if (bit_idx == 63) begin
         frames++;
         if (expq.size() == 0) begin
            chk("R3 unexpected frame", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk("R5 frame header", {18'd0, cap_o[63:18]}, {18'd0, e.bits[63:18]});
            if (!e.rd) begin
               chk("R6 turnaround and data", {46'd0, cap_o[17:0]}, {46'd0, e.bits[17:0]});
               chk("R6 line driven", cap_oe, {64{1'b1}});
            end else begin
               chk("R7 line released", cap_oe, {{46{1'b1}}, 18'd0});
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         rd(2'd0, v);
         if (!v[20]) return;
      end
      chk("R9 busy never cleared", 64'd1, 64'd0);
   endtask

   function automatic logic [31:0] cmd_word(bit r, logic [4:0] phy, logic [4:0] rg);
      return (32'd1 << 20) | (r ? (32'd1 << 17) : (32'd1 << 16)) |
             {19'd0, phy, 3'd0, rg};
   endfunction

   logic [15:0] data_low = 16'h0;
   logic        last_inv = 1'b0;

   task automatic push_exp(bit r, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
      exp_t e;
      e.rd   = r;
      e.bits = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
      expq.push_back(e);
   endtask

   task automatic mgmt(bit r, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                       logic [15:0] rsp, bit ta_ok);
      logic [31:0] v;
      if (!r) begin
         wr(2'd1, {16'h0, wd});
         data_low = wd;
      end
      push_exp(r, phy, rg, wd);
      resp = rsp;
      ta_drive = ta_ok ? 1'b0 : 1'b1;
      bit_idx = 0;
      wr(2'd0, cmd_word(r, phy, rg));
      rd(2'd0, v);
      chk("R2 busy set after accept", 64'(v[20]), 64'd1);
      wait_idle();
      chk("R9 line released when idle", 64'(mdio_oe), 64'd0);
      chk("R4 clock low when idle", 64'(mdc), 64'd0);
      if (r) begin
         rd(2'd1, v);
         chk("R7 read data upper half", 64'(v[31:16]), 64'(rsp));
         chk("R7 lower half kept", 64'(v[15:0]), 64'(data_low));
         rd(2'd2, v);
         last_inv = !ta_ok;
         chk("R8 invalid flag after read", 64'(v[0]), 64'(last_inv));
      end else begin
         rd(2'd2, v);
         chk("R8 flag kept across write", 64'(v[0]), 64'(last_inv));
      end
   endtask

   initial begin
      logic [31:0] v;
      int          f0;
      repeat (4) @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 command reset", 64'(v), 64'd0);
      rd(2'd1, v); chk("R1 data reset", 64'(v), 64'd0);
      rd(2'd2, v); chk("R1 status reset", 64'(v), 64'd0);
      chk("R1 clock and enable low", {62'd0, mdc, mdio_oe}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      mgmt(1'b0, 5'h01, 5'h00, 16'h1234, 16'h0, 1'b1);
      mgmt(1'b0, 5'h1F, 5'h1E, 16'h8001, 16'h0, 1'b1);
      mgmt(1'b1, 5'h03, 5'h02, 16'h0, 16'hBEEF, 1'b1);
      mgmt(1'b1, 5'h0A, 5'h15, 16'h0, 16'h5A5A, 1'b0);
      mgmt(1'b0, 5'h10, 5'h01, 16'hC3C3, 16'h0, 1'b1);

      // R3: second command while the first runs
      push_exp(1'b0, 5'h04, 5'h07, data_low);
      bit_idx = 0;
      wr(2'd0, cmd_word(1'b0, 5'h04, 5'h07));
      wr(2'd0, cmd_word(1'b1, 5'h19, 5'h0C));
      rd(2'd0, v);
      chk("R3 command fields kept while busy", 64'(v), 64'(cmd_word(1'b0, 5'h04, 5'h07)));
      wait_idle();
      chk("R3 only one frame", 64'(frames), 64'd6);

      // R2: malformed commands
      f0 = frames;
      wr(2'd0, (32'd1 << 20) | (32'd3 << 16) | 32'h0000_0305);
      rd(2'd0, v);
      chk("R2 both op bits ignored", 64'(v[20]), 64'd0);
      wr(2'd0, (32'd1 << 17) | 32'h0000_0305);
      rd(2'd0, v);
      chk("R2 missing busy bit ignored", 64'(v[20]), 64'd0);
      repeat (300) @(negedge clk);
      chk("R2 no frame from bad commands", 64'(frames), 64'(f0));

      mgmt(1'b1, 5'h15, 5'h0A, 16'h0, 16'h0F0F, 1'b1);
      chk("R5 scoreboard drained", 64'(expq.size()), 64'd0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R9 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule